// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines and presents a single interrupt signal to a processor. Each line is captured into a pending register, qualified by a software mask and by a priority barrier derived from the in-service register, and arbitrated with line 0 as the most urgent. When the processor acknowledges, the block returns an 8-bit vector and moves the winning request from pending to in-service.

Software talks to the block through a two-address register port. The command address carries the initialization word that starts a setup sequence, end-of-interrupt commands and a read-select command. The data address carries the remaining setup words and, once setup is done, the interrupt mask. Setup selects edge or level request capture and whether acknowledge ends the interrupt automatically. `rdata` is combinational from `addr`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is 0xFF, pending and in-service are 0, `int_out` is 0, a command-address read returns in-service, and the vector base is 0.
- R2: A command write with bit 4 = 1 (setup word 1) clears the mask, the in-service register and the auto-EOI flag. It stores bit 3 (1 = level capture), bit 1 (single mode) and bit 0 (word 4 follows). The next data write is then taken as setup word 2.
- R3: Setup word 2 sets the vector base to the written value AND 0xF8. The sequencer then goes to word 4 if the single-mode flag is set, and to word 3 if it is clear.
- R4: After word 3 the sequencer goes to word 4 if the word-4 flag is set, and otherwise to normal operation. Word 4 bit 1 sets the auto-EOI flag, and the sequencer then returns to normal operation.
- R5: In normal operation a data write loads the mask (bit n = 1 masks line n). A data-address read always returns the mask.
- R6: A command write with bit 4 = 0 and bit 3 = 1 is a read-select command. When its bit 1 is 1, its bit 0 chooses what command-address reads return: in-service (1) or pending (0). When its bit 1 is 0, the read selection is unchanged.
- R7: In edge mode a pending bit is set only on a rising edge of its line. A line held high is not pended again after acknowledge or EOI.
- R8: In level mode a pending bit clears while its line is low. When an EOI clears an in-service bit whose line is still high, that line is pended again.
- R9: `int_out` is 1 exactly when some line is pending, unmasked and not blocked. A line is blocked when its number is at or above the lowest set in-service bit.
- R10: While `ack` is 1, `vector` equals base + n for the lowest-numbered qualifying line n. On that clock edge, pending bit n clears and in-service bit n sets. With no qualifying line, `vector` is 0xFF and no state changes.
- R11: A command write with bit 4 = 0, bit 3 = 0 and bits 7:5 = 011 clears the in-service bit selected by bits 2:0.
- R12: Any other command write with bits 4 and 3 both 0 clears the lowest-numbered set in-service bit.
- R13: With auto-EOI set, acknowledge clears the pending bit and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current `addr` |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Interrupt acknowledge, one cycle |
| vector | output | 8 | Vector for the acknowledge in progress |

## Verification
The assertions assume that `ack` and `wr_en` are never high in the same cycle. They also assume that request lines change only between clock edges, so that the registered copy of a line is a true history. The stimulus drives every input on the falling clock edge and runs each register access, acknowledge and request change in a cycle of its own. An acknowledge never overlaps a write. The pending-source check relies on every new pending bit having its line high in the previous cycle. This holds because the bench only raises a line and then waits, and never creates a pulse shorter than a clock.

// File: rtl/pic_pkg.sv
// Package: shared types and sizes for the priority interrupt controller.
// Assumes an 8-bit register port and eight request lines.
package pic_pkg;
    localparam int unsigned NUM_IRQ = 8;
    localparam int unsigned IDX_W   = $clog2(NUM_IRQ);

    // Setup sequencer state: normal operation or waiting for a setup word.
    typedef enum logic [1:0] {
        SEQ_RUN = 2'd0,
        SEQ_W2  = 2'd1,
        SEQ_W3  = 2'd2,
        SEQ_W4  = 2'd3
    } seq_e;
endpackage

// File: rtl/pic_first_set.sv
// Module: finds the lowest-numbered set bit of a vector.
// Assumes nothing about the input; idx is zero when found is low.
module pic_first_set #(
    parameter int unsigned N  = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_init_seq.sv
// Module: decodes register writes and holds the setup state. It holds the
// sequencer, vector base, capture mode, auto-EOI flag, read select and mask.
// Assumes writes are single-cycle strobes and addr is stable with wr_en.
module pic_init_seq
    import pic_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] vec_base,
    output logic          level_mode,
    output logic          auto_eoi,
    output logic          read_isr,
    output logic          init_stb,
    output logic          eoi_stb
);
    seq_e state;
    logic single_f, need_w4_f;
    logic cmd_wr, data_wr, sel_stb;

    // Decode the command-address write kinds.
    always_comb begin
        cmd_wr   = wr_en && !addr;
        data_wr  = wr_en && addr;
        init_stb = cmd_wr && wdata[4];
        eoi_stb  = cmd_wr && !wdata[4] && !wdata[3];
        sel_stb  = cmd_wr && !wdata[4] && wdata[3];
    end

    // Step the setup sequencer and update the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_RUN;
            mask       <= '1;
            vec_base   <= '0;
            level_mode <= 1'b0;
            auto_eoi   <= 1'b0;
            read_isr   <= 1'b1;
            single_f   <= 1'b0;
            need_w4_f  <= 1'b0;
        end else if (init_stb) begin
            state      <= SEQ_W2;
            mask       <= '0;
            auto_eoi   <= 1'b0;
            level_mode <= wdata[3];
            single_f   <= wdata[1];
            need_w4_f  <= wdata[0];
        end else if (sel_stb) begin
            if (wdata[1]) read_isr <= wdata[0];
        end else if (data_wr) begin
            unique case (state)
                SEQ_RUN: mask <= wdata;
                SEQ_W2: begin
                    vec_base <= wdata & ~DW'(7);
                    state    <= single_f ? SEQ_W4 : SEQ_W3;
                end
                SEQ_W3:  state <= need_w4_f ? SEQ_W4 : SEQ_RUN;
                SEQ_W4: begin
                    auto_eoi <= wdata[1];
                    state    <= SEQ_RUN;
                end
            endcase
        end
    end

    p_init_enters_w2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_stb |=> state == SEQ_W2);
    p_init_clears_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_stb |=> mask == '0);
    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !init_stb && !sel_stb && state == SEQ_RUN) |=> mask == $past(wdata));
    p_base_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_base[2:0] == 3'b000);
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: eight-line priority interrupt controller top. It holds the pending
// and in-service registers and does arbitration, acknowledge and EOI.
// Assumes ack and wr_en are never asserted together and that irq_in is
// synchronous to clk.
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned N  = NUM_IRQ,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         addr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] rdata,
    input  logic [N-1:0] irq_in,
    output logic         int_out,
    input  logic         ack,
    output logic [N-1:0] vector
);
    logic [N-1:0]  mask, vec_base, pend, isr, irq_prev;
    logic [N-1:0]  pend_n, isr_n, blk, cand, rise;
    logic          level_mode, auto_eoi, read_isr, init_stb, eoi_stb;
    logic          isr_any, cand_any, eoi_ok;
    logic [IW-1:0] isr_idx, cand_idx, eoi_idx;

    pic_init_seq #(.DW(N)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mask(mask), .vec_base(vec_base), .level_mode(level_mode),
        .auto_eoi(auto_eoi), .read_isr(read_isr),
        .init_stb(init_stb), .eoi_stb(eoi_stb)
    );

    pic_first_set #(.N(N)) u_isr_low  (.vec(isr),  .found(isr_any),  .idx(isr_idx));
    pic_first_set #(.N(N)) u_cand_low (.vec(cand), .found(cand_any), .idx(cand_idx));

    // Build the priority barrier and the qualified request set.
    always_comb begin
        blk     = isr_any ? ({N{1'b1}} << isr_idx) : '0;
        cand    = pend & ~mask & ~blk;
        int_out = cand_any;
        vector  = cand_any ? (vec_base | N'(cand_idx)) : '1;
        rdata   = addr ? mask : (read_isr ? isr : pend);
    end

    // Choose the in-service bit that an EOI command retires.
    always_comb begin
        if (wdata[7:5] == 3'b011) begin
            eoi_idx = wdata[IW-1:0];
            eoi_ok  = 1'b1;
        end else begin
            eoi_idx = isr_idx;
            eoi_ok  = isr_any;
        end
    end

    // Compute the next pending and in-service values.
    always_comb begin
        rise   = irq_in & ~irq_prev;
        pend_n = pend | rise;
        if (level_mode) pend_n = pend_n & irq_in;
        isr_n  = isr;
        if (init_stb) begin
            isr_n = '0;
        end else if (eoi_stb && eoi_ok) begin
            isr_n[eoi_idx] = 1'b0;
            if (level_mode && irq_in[eoi_idx]) pend_n[eoi_idx] = 1'b1;
        end
        if (ack && cand_any) begin
            pend_n[cand_idx] = 1'b0;
            if (auto_eoi) begin
                if (level_mode && irq_in[cand_idx]) pend_n[cand_idx] = 1'b1;
            end else begin
                isr_n[cand_idx] = 1'b1;
            end
        end
    end

    // Register the request history, pending and in-service state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= '0;
            isr      <= '0;
            irq_prev <= '0;
        end else begin
            pend     <= pend_n;
            isr      <= isr_n;
            irq_prev <= irq_in;
        end
    end

    p_pend_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) & ~$past(irq_in)) == '0);
    p_int_needs_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (pend & ~mask) != '0);
    p_empty_ack_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out) |-> vector == '1);
    p_ack_sets_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !auto_eoi && !wr_en) |=> isr != '0);
    p_auto_keeps_isr_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi && !wr_en) |=> (isr & ~$past(isr)) == '0);
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] irq_in = '0;
    logic       int_out;
    logic       ack = 1'b0;
    logic [7:0] vector;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_vec[$];
    string      exp_tag[$];
    logic [7:0] v;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .ack(ack), .vector(vector)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        @(negedge clk); addr = a; #2 d = rdata;
    endtask

    task automatic set_irq(logic [7:0] d);
        @(negedge clk); irq_in = d;
    endtask

    task automatic chk_int(string tag, logic exp);
        @(negedge clk); #2 check(tag, {7'b0, int_out}, {7'b0, exp});
    endtask

    // Driver: push the expected vector, then pulse acknowledge.
    task automatic do_ack(string tag, logic [7:0] exp);
        @(negedge clk);
        exp_vec.push_back(exp); exp_tag.push_back(tag);
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    // Monitor: pop and compare the vector of each acknowledge.
    always @(negedge clk) begin
        #3;
        if (ack) begin
            if (exp_vec.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10 unexpected ack actual=%02h expected=none", vector);
            end else begin
                check(exp_tag.pop_front(), vector, exp_vec.pop_front());
            end
        end
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(1'b0, v); check("R1 isr", v, 8'h00);
        rd(1'b1, v); check("R1 mask", v, 8'hFF);
        chk_int("R1 int", 1'b0);
        do_ack("R1/R10 empty ack", 8'hFF);

        // R2/R3/R4: full sequence, edge mode, word 4 present
        wr(1'b0, 8'h11); rd(1'b1, v); check("R2 mask cleared", v, 8'h00);
        wr(1'b1, 8'h25); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        wr(1'b1, 8'h5A); rd(1'b1, v); check("R5 mask", v, 8'h5A);
        wr(1'b1, 8'h00);

        // R6 select pending, R7 edge capture
        wr(1'b0, 8'h0A); rd(1'b0, v); check("R6 pend empty", v, 8'h00);
        set_irq(8'h08); rd(1'b0, v); check("R7 pend rise", v, 8'h08);
        chk_int("R9 int pending", 1'b1);
        wr(1'b1, 8'h08); chk_int("R9 masked", 1'b0);
        wr(1'b1, 8'h00);
        set_irq(8'h28);
        do_ack("R10 vec line3", 8'h23);
        rd(1'b0, v); check("R10 pend after ack", v, 8'h20);
        wr(1'b0, 8'h0B); rd(1'b0, v); check("R10 isr after ack", v, 8'h08);
        chk_int("R9 blocked by priority", 1'b0);
        set_irq(8'h2A); chk_int("R9 higher line", 1'b1);
        do_ack("R10 vec line1", 8'h21);
        rd(1'b0, v); check("R10 isr two", v, 8'h0A);
        wr(1'b0, 8'h20); rd(1'b0, v); check("R12 nonspecific", v, 8'h08);
        wr(1'b0, 8'h63); rd(1'b0, v); check("R11 specific", v, 8'h00);
        do_ack("R10 vec line5", 8'h25);
        wr(1'b0, 8'h20);
        wr(1'b0, 8'h0A); rd(1'b0, v); check("R7 no repend", v, 8'h00);
        chk_int("R7 int idle", 1'b0);
        set_irq(8'h00);

        // R8: level mode
        wr(1'b0, 8'h19); wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h01);
        set_irq(8'h04); rd(1'b0, v); check("R8 level pend", v, 8'h04);
        do_ack("R10 vec level", 8'h42);
        rd(1'b0, v); check("R8 pend cleared by ack", v, 8'h00);
        wr(1'b0, 8'h20); rd(1'b0, v); check("R8 repend on eoi", v, 8'h04);
        set_irq(8'h00); rd(1'b0, v); check("R8 drop clears", v, 8'h00);
        wr(1'b0, 8'h08); rd(1'b0, v); check("R6 select unchanged", v, 8'h00);
        set_irq(8'h40); do_ack("R10 vec line6", 8'h46);
        set_irq(8'h00);
        wr(1'b0, 8'h0B); rd(1'b0, v); check("R6 isr select", v, 8'h40);

        // R2 clears in-service; R3 single path goes to word 4; R13 auto-EOI
        wr(1'b0, 8'h13); rd(1'b0, v); check("R2 isr cleared", v, 8'h00);
        wr(1'b1, 8'h87); wr(1'b1, 8'h02); wr(1'b1, 8'hFE);
        rd(1'b1, v); check("R3 single path mask", v, 8'hFE);
        set_irq(8'h01); chk_int("R9 line0", 1'b1);
        do_ack("R3 base aligned", 8'h80);
        rd(1'b0, v); check("R13 isr untouched", v, 8'h00);
        set_irq(8'h00);

        // R4: no word 4
        wr(1'b0, 8'h10); wr(1'b1, 8'h08); wr(1'b1, 8'h00); wr(1'b1, 8'h33);
        rd(1'b1, v); check("R4 run after word3", v, 8'h33);

        repeat (4) @(negedge clk);
        if (exp_vec.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10 missing acks actual=%0d expected=0", exp_vec.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule